// File: doc/BRIEF.md
# Quad Channel Converter Serial Register Interface

This block is the serial slave front end of a four-channel 12-bit converter. A host frames each transaction with an active-low select line and clocks in one 16-bit word, most significant bit first. The top bit chooses write or readback, the next three bits pick a target, and the low twelve bits carry data. Writes land in one of four channel input registers, in all four at once through a broadcast address, or in a control register. Readback returns a register's contents on the serial output during the twelve data clocks of the same frame.

All pins are sampled by a fast system clock through a synchronizer, and edges of the select and serial clock lines are detected in that clock domain. The serial clock does not have to run continuously. The four channel values and the control word come out as parallel outputs for the converter core. The serial output carries its own enable, and one control bit tells the pad which idle state to use.

Top module: `qdac_spi_regif`

## Requirements
- R1: After reset all four channel registers and the control register read zero, `sdo_oe` is 0 and `sdo_pd_sel` is 0.
- R2: A frame is word bit 15 = R/W (0 write, 1 read), bits 14:12 = address, bits 11:0 = data, shifted MSB first and sampled on falling SCLK edges. A write to address 1, 2, 3 or 4 loads channel A, B, C or D (`ch_data` slices [11:0], [23:12], [35:24], [47:36]). It takes effect only on the 16th falling edge and not after 15.
- R3: A write to address 5 loads the data into all four channel registers.
- R4: A write to address 7 loads the control register, and `sdo_pd_sel` equals control bit 6.
- R5: Writes to address 0 or 6 change no register.
- R6: If SYNC rises before the 16th falling SCLK edge, the partial frame is discarded and no register changes.
- R7: SCLK pulses after the 16th falling edge while SYNC stays low are ignored. A new frame starts only on a fresh SYNC falling edge.
- R8: In a read frame the addressed register is sent on `sdo` MSB first, one bit per pulse from the rising edge of SCLK pulse 5 through pulse 16, valid at each following falling edge. Addresses 0, 5 and 6 return zero. A read changes no register.
- R9: `sdo_oe` is 0 through the first four SCLK pulses. In a read frame it rises on the rising edge of pulse 5 and falls after the 16th falling edge, or earlier when SYNC rises. It stays 0 in write frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, samples all serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_n | input | 1 | Frame select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (0 when not enabled) |
| sdo_oe | output | 1 | Output enable for the serial data pad |
| sdo_pd_sel | output | 1 | Idle state of SDO: 1 weak pull-down, 0 high impedance |
| ch_data | output | 48 | Four 12-bit channel input registers, channel A in the low slice |
| ctrl_data | output | 12 | Control register |

## Verification
The bench builds the block with its default parameters: 12-bit data, a 3-bit address and a two-stage synchronizer. The serial clock runs at five system clocks per phase, so every serial edge passes through the synchronizer and edge detector before the bench samples at the opposite edge. This setting reaches the exact 15th and 16th falling edges, aborts at any bit position, surplus pulses after a complete frame, and readback of every address with the enable window checked on each pulse.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  localparam int QD_AW = 3;
  localparam int QD_CH = 4;

  typedef enum logic [QD_AW-1:0] {
    A_NOP = 3'd0,
    A_CHA = 3'd1,
    A_CHB = 3'd2,
    A_CHC = 3'd3,
    A_CHD = 3'd4,
    A_ALL = 3'd5,
    A_RSV = 3'd6,
    A_CTL = 3'd7
  } qd_addr_e;

  // Channel write-enable mask for a target address
  function automatic logic [QD_CH-1:0] f_ch_mask(input logic [QD_AW-1:0] a);
    logic [QD_CH-1:0] m;
    case (a)
      A_CHA:   m = 4'b0001;
      A_CHB:   m = 4'b0010;
      A_CHC:   m = 4'b0100;
      A_CHD:   m = 4'b1000;
      A_ALL:   m = 4'b1111;
      default: m = 4'b0000;
    endcase
    return m;
  endfunction

  function automatic logic f_is_ctl(input logic [QD_AW-1:0] a);
    return a == A_CTL;
  endfunction

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) st[g] <= RST_VAL;
        else        st[g] <= st[g-1];
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_n_s,
  input  logic               sclk_s,
  input  logic               sdi_s,
  output logic               active,
  output logic [CNT_W-1:0]   cnt,
  output logic               sclk_rise,
  output logic               commit,
  output logic               abort,
  output logic [FRAME_W-1:0] word,
  output logic [FRAME_W-1:0] word_next
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic sync_d, sclk_d;
  logic sync_fall, sync_rise, sclk_fall, take_bit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync_d <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      sync_d <= sync_n_s;
      sclk_d <= sclk_s;
    end

  assign sync_fall = sync_d & ~sync_n_s;
  assign sync_rise = ~sync_d & sync_n_s;
  assign sclk_fall = sclk_d & ~sclk_s;
  assign sclk_rise = active & ~sclk_d & sclk_s;

  assign take_bit  = active & sclk_fall & (cnt != CNT_FULL);
  assign commit    = take_bit & (cnt == CNT_LAST);
  assign abort     = active & sync_rise & (cnt != CNT_FULL);
  assign word_next = {word[FRAME_W-2:0], sdi_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      word   <= '0;
    end else if (sync_fall) begin
      active <= 1'b1;
      cnt    <= '0;
      word   <= '0;
    end else if (sync_rise) begin
      active <= 1'b0;
    end else if (take_bit) begin
      word   <= word_next;
      cnt    <= cnt + 1'b1;
    end

endmodule

// File: rtl/qdac_regfile.sv
module qdac_regfile
  import qdac_pkg::*;
#(
  parameter int DW = 12,
  parameter int CH = QD_CH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [QD_AW-1:0] wr_addr,
  input  logic [DW-1:0]    wr_data,
  output logic [CH*DW-1:0] ch_data,
  output logic [DW-1:0]    ctrl_data
);

  logic [QD_CH-1:0] mask;
  assign mask = f_ch_mask(wr_addr);

  for (genvar c = 0; c < CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                 ch_data[c*DW +: DW] <= '0;
      else if (wr_en && mask[c])  ch_data[c*DW +: DW] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                          ctrl_data <= '0;
    else if (wr_en && f_is_ctl(wr_addr)) ctrl_data <= wr_data;

endmodule

// File: rtl/qdac_readout.sv
module qdac_readout #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          sclk_rise,
  input  logic          stop,
  input  logic [DW-1:0] rd_val,
  output logic          sdo,
  output logic          sdo_oe
);

  logic [DW-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      shreg  <= '0;
      sdo_oe <= 1'b0;
    end else if (stop) begin
      sdo_oe <= 1'b0;
    end else if (load) begin
      shreg  <= rd_val;
      sdo_oe <= 1'b1;
    end else if (sdo_oe && sclk_rise) begin
      shreg  <= {shreg[DW-2:0], 1'b0};
    end

  assign sdo = sdo_oe & shreg[DW-1];

endmodule

// File: rtl/qdac_spi_regif.sv
module qdac_spi_regif
  import qdac_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2,
  parameter int PD_BIT      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sync_n,
  input  logic                    sclk,
  input  logic                    sdi,
  output logic                    sdo,
  output logic                    sdo_oe,
  output logic                    sdo_pd_sel,
  output logic [QD_CH*DATA_W-1:0] ch_data,
  output logic [DATA_W-1:0]       ctrl_data
);

  localparam int FRAME_W = 1 + QD_AW + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int HDR_W   = 1 + QD_AW;
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(HDR_W);

  // Named internal events, observed by the bound checker
  logic [2:0]         pins_s;
  logic               frame_active;
  logic [CNT_W-1:0]   bit_cnt;
  logic               sclk_rise;
  logic               commit;
  logic               abort;
  logic [FRAME_W-1:0] word_q;
  logic [FRAME_W-1:0] word_next;
  logic               cmt_rw;
  logic [QD_AW-1:0]   cmt_addr;
  logic [DATA_W-1:0]  cmt_data;
  logic               hdr_rw;
  logic [QD_AW-1:0]   hdr_addr;
  logic               rd_load;
  logic [DATA_W-1:0]  rd_val;

  qdac_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sync_n, sclk, sdi}),
    .q     (pins_s)
  );

  qdac_frame_rx #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .sync_n_s  (pins_s[2]),
    .sclk_s    (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .active    (frame_active),
    .cnt       (bit_cnt),
    .sclk_rise (sclk_rise),
    .commit    (commit),
    .abort     (abort),
    .word      (word_q),
    .word_next (word_next)
  );

  assign cmt_rw   = word_next[FRAME_W-1];
  assign cmt_addr = word_next[FRAME_W-2 -: QD_AW];
  assign cmt_data = word_next[DATA_W-1:0];

  // Header is complete in the low bits once HDR_W bits are in
  assign hdr_rw   = word_q[QD_AW];
  assign hdr_addr = word_q[QD_AW-1:0];
  assign rd_load  = sclk_rise & hdr_rw & (bit_cnt == CNT_HDR);

  qdac_regfile #(.DW(DATA_W), .CH(QD_CH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (commit & ~cmt_rw),
    .wr_addr   (cmt_addr),
    .wr_data   (cmt_data),
    .ch_data   (ch_data),
    .ctrl_data (ctrl_data)
  );

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < QD_CH; c++)
      if (hdr_addr == QD_AW'(c + 1)) rd_val = ch_data[c*DATA_W +: DATA_W];
    if (f_is_ctl(hdr_addr)) rd_val = ctrl_data;
  end

  qdac_readout #(.DW(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (rd_load),
    .sclk_rise (sclk_rise),
    .stop      (commit | abort),
    .rd_val    (rd_val),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe)
  );

  assign sdo_pd_sel = ctrl_data[PD_BIT];

endmodule

// File: rtl/qdac_spi_regif_chk.sv
module qdac_spi_regif_chk #(
  parameter int DW      = 12,
  parameter int CH      = 4,
  parameter int AW      = 3,
  parameter int CNT_W   = 5,
  parameter int FRAME_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_active,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             commit,
  input logic             abort,
  input logic             cmt_rw,
  input logic [AW-1:0]    cmt_addr,
  input logic [DW-1:0]    cmt_data,
  input logic             sdo_oe,
  input logic [CH*DW-1:0] ch_data,
  input logic [DW-1:0]    ctrl_data
);

  logic all_eq;
  always_comb begin
    all_eq = 1'b1;
    for (int c = 1; c < CH; c++)
      if (ch_data[c*DW +: DW] != ch_data[DW-1:0]) all_eq = 1'b0;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W)); // R2
  AST_BCAST_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cmt_rw && cmt_addr == AW'(5) |=> all_eq && ch_data[DW-1:0] == $past(cmt_data)); // R3
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cmt_rw && cmt_addr == AW'(7) |=> ctrl_data == $past(cmt_data)); // R4
  AST_NOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !cmt_rw && (cmt_addr == AW'(0) || cmt_addr == AW'(6)) |=> $stable(ch_data) && $stable(ctrl_data)); // R5
  AST_ABORT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> $stable(ch_data) && $stable(ctrl_data)); // R6
  AST_FULL_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt == CNT_W'(FRAME_W) |-> !commit); // R7
  AST_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    commit && cmt_rw |=> $stable(ch_data) && $stable(ctrl_data)); // R8
  AST_OE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> bit_cnt == CNT_W'(AW + 1)); // R9
  AST_OE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> frame_active); // R9

endmodule

bind qdac_spi_regif qdac_spi_regif_chk #(
  .DW(DATA_W), .CH(qdac_pkg::QD_CH), .AW(qdac_pkg::QD_AW), .CNT_W(CNT_W), .FRAME_W(FRAME_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_active (frame_active),
  .bit_cnt      (bit_cnt),
  .commit       (commit),
  .abort        (abort),
  .cmt_rw       (cmt_rw),
  .cmt_addr     (cmt_addr),
  .cmt_data     (cmt_data),
  .sdo_oe       (sdo_oe),
  .ch_data      (ch_data),
  .ctrl_data    (ctrl_data)
);

// File: tb/sim_qdac_spi_regif.sv
module sim_qdac_spi_regif;

  localparam int H = 5; // system clocks per SCLK phase

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe, sdo_pd_sel;
  logic [47:0] ch_data;
  logic [11:0] ctrl_data;

  always #10 clk = ~clk;

  qdac_spi_regif u0 (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .sdo_pd_sel(sdo_pd_sel),
    .ch_data(ch_data), .ctrl_data(ctrl_data)
  );

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;
  logic [11:0] m_ch [4];
  logic [11:0] m_ctl;
  logic [11:0] rd_acc;
  int oe_bad;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Bench-side model of the register map
  function automatic void m_apply(input logic [15:0] w);
    logic [2:0] a = w[14:12];
    if (w[15]) return;
    if (a >= 3'd1 && a <= 3'd4) m_ch[a-1] = w[11:0];
    else if (a == 3'd5) for (int c = 0; c < 4; c++) m_ch[c] = w[11:0];
    else if (a == 3'd7) m_ctl = w[11:0];
  endfunction

  function automatic logic [11:0] m_read(input logic [2:0] a);
    if (a >= 3'd1 && a <= 3'd4) return m_ch[a-1];
    if (a == 3'd7) return m_ctl;
    return 12'h000;
  endfunction

  task automatic check_regs(input string req);
    logic [47:0] e = {m_ch[3], m_ch[2], m_ch[1], m_ch[0]};
    chk(ch_data === e, {req, " channels"}, 64'(ch_data), 64'(e));
    chk(ctrl_data === m_ctl && sdo_pd_sel === m_ctl[6], {req, " control/R4 pd"},
        64'({sdo_pd_sel, ctrl_data}), 64'({m_ctl[6], m_ctl}));
  endtask

  task automatic pulses(input logic [15:0] w, input int from, input int to, input bit rd);
    for (int i = from; i <= to; i++) begin
      sdi = w[15-i];
      sclk = 1'b1;
      wclk(H);
      if (sdo_oe !== (rd && i >= 4)) oe_bad++;
      if (rd && i >= 4) rd_acc = {rd_acc[10:0], sdo};
      sclk = 1'b0;
      wclk(H);
    end
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input string req);
    logic [11:0] exp_rd = m_read(w[14:12]);
    oe_bad = 0;
    rd_acc = '0;
    sync_n = 1'b0;
    wclk(H);
    pulses(w, 0, nbits - 1, w[15]);
    sync_n = 1'b1;
    wclk(H);
    chk(oe_bad == 0 && sdo_oe === 1'b0, {req, " R9 enable window"}, 64'(oe_bad), 64'(0));
    if (nbits == 16) begin
      m_apply(w);
      if (w[15]) chk(rd_acc === exp_rd, {req, " R8 readback"}, 64'(rd_acc), 64'(exp_rd));
    end
    check_regs(req);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    for (int c = 0; c < 4; c++) m_ch[c] = '0;
    m_ctl = '0;
    void'($urandom(32'h1234_5eed));
    wclk(4);
    rst_n = 1'b1;
    wclk(4);

    // R1 reset state
    check_regs("R1");
    chk(sdo_oe === 1'b0, "R1 oe", 64'(sdo_oe), 64'(0));

    // R2 single channel writes
    frame(16'h1123, 16, "R2 A");
    frame(16'h2456, 16, "R2 B");
    frame(16'h3789, 16, "R2 C");
    frame(16'h4ABC, 16, "R2 D");

    // R2 no effect after 15 edges, effect on the 16th
    oe_bad = 0;
    sync_n = 1'b0;
    wclk(H);
    pulses(16'h2DEF, 0, 14, 1'b0);
    chk(ch_data[23:12] === 12'h456, "R2 before 16th edge", 64'(ch_data[23:12]), 64'h456);
    pulses(16'h2DEF, 15, 15, 1'b0);
    chk(ch_data[23:12] === 12'hDEF, "R2 on 16th edge", 64'(ch_data[23:12]), 64'hDEF);
    sync_n = 1'b1;
    wclk(H);
    m_apply(16'h2DEF);
    check_regs("R2");

    // R3 broadcast
    frame(16'h55A5, 16, "R3");

    // R4 control and pull-down select
    frame(16'h7040, 16, "R4 pd on");
    frame(16'h70BF, 16, "R4 pd off");

    // R5 no-op and reserved
    frame(16'h0FFF, 16, "R5 nop");
    frame(16'h6FFF, 16, "R5 reserved");

    // R6 aborted writes
    frame(16'h1333, 10, "R6 abort 10");
    frame(16'h5777, 15, "R6 abort 15");

    // R7 surplus pulses with SYNC held low
    oe_bad = 0;
    sync_n = 1'b0;
    wclk(H);
    pulses(16'h3111, 0, 15, 1'b0);
    pulses(16'h4222, 0, 15, 1'b0);
    sync_n = 1'b1;
    wclk(H);
    m_apply(16'h3111);
    chk(ch_data[47:36] === m_ch[3], "R7 surplus ignored", 64'(ch_data[47:36]), 64'(m_ch[3]));
    chk(oe_bad == 0, "R7 oe stays low", 64'(oe_bad), 64'(0));
    check_regs("R7");

    // R8 readback of every address
    frame(16'h1A1A, 16, "R8 setup");
    for (int a = 0; a < 8; a++) frame({1'b1, 3'(a), 12'hFFF}, 16, "R8 read");

    // R9 read aborted mid data
    frame(16'h9000, 8, "R9 read abort");
    frame(16'hF000, 4, "R9 read abort at header");

    // Random mix
    for (int k = 0; k < 80; k++) begin
      logic [15:0] w = 16'($urandom);
      int n = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 15) : 16;
      frame(w, n, "R2 random");
    end

    done = 1'b1;
    finish_run();
  end

endmodule